// File: doc/BRIEF.md
# Memory Sequence Game Controller

This block runs a repeat-the-pattern game on four LEDs and four player buttons. A start press in idle begins the first round. The controller replays a fixed rotating pattern on the LEDs, one entry at a time, from entry 0 up to the current score. It then waits for the player to repeat that prefix with button presses and checks each press in turn. When a round is completed correctly, the score goes up by one and the longer prefix is replayed. A wrong press ends the game in a loss. Reaching the final score ends it in a win.

All timing is counted in ticks of a clock-enable input, so the same block can run from any divided time base. Each replayed entry is lit for a set number of ticks and then followed by a dark gap, so two equal entries in a row still appear as separate flashes. Each captured press is echoed on the LEDs for a hold time before it is judged. Buttons are taken as clean, synchronous pulses. There is no debouncing and no random pattern source.

Top module: `memseq_game`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the game returns to idle: `led` is 0, `score` is 0, and `waiting`, `won` and `lost` are all 0.
- R2: In idle, `start` high begins the replay of the first round. Button presses in idle have no effect on any output.
- R3: Pattern entry i is one-hot, with only bit (i mod 4) of `led` set: 0001, 0010, 0100, 1000, and then the cycle repeats.
- R4: The replay shows entries 0 through `score` in order. Each entry is lit for SHOW_TICKS ticks and followed by GAP_TICKS ticks with `led` at 0. At most one LED is lit during the replay.
- R5: After the gap that follows the last shown entry, `waiting` goes high and stays high until a nonzero button vector arrives.
- R6: A nonzero `btn` while `waiting` is high is captured. From the next cycle, `waiting` is low and `led` shows the captured vector for HOLD_TICKS ticks.
- R7: A captured press that equals the expected entry, with the check position below `score`, returns the game to `waiting` for the next entry. `score` does not change.
- R8: A correct press at the check position equal to `score` increments `score` and starts a new replay from entry 0.
- R9: Any press that differs from the expected entry, including a vector with more than one bit set, sets `lost`. `score` keeps the value of the round that failed.
- R10: When `score` reaches WIN_SCORE, `won` is set.
- R11: `won` and `lost` persist with `led` dark and `waiting` low. `start` and `btn` are ignored until `rst_n` is low.
- R12: Timed intervals advance only on cycles with `tick` high. With `tick` low, a lit LED stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Clock-enable for all timed intervals |
| start | input | 1 | Start request, acted on only in idle |
| btn | input | 4 | Player buttons, one bit per LED |
| led | output | 4 | LED drive for replay and press echo |
| waiting | output | 1 | High while a player press is expected |
| won | output | 1 | Game ended in a win |
| lost | output | 1 | Game ended in a loss |
| score | output | $clog2(WIN_SCORE+1) | Number of rounds completed |

## Verification
The checker watches the local rules on every cycle. These are the reset values, score moving only by +1, press capture and echo, LEDs frozen when no tick arrives, and the end states being sticky with the LEDs dark. Other behaviour spans a whole round, so only the bench scenarios can show it. That covers the order and one-hot values of the replayed prefix, the exact lit and dark durations, the decision between advancing, replaying, losing and winning, and a full game played up to the win. The constrained-random games vary the tick density, the round that fails and the step that fails.

// File: rtl/memseq_game.sv
module memseq_game #(
  parameter int SHOW_TICKS = 400,
  parameter int GAP_TICKS  = 100,
  parameter int HOLD_TICKS = 300,
  parameter int WIN_SCORE  = 15,
  localparam int SW   = $clog2(WIN_SCORE + 1),
  localparam int MAXT = (SHOW_TICKS > GAP_TICKS) ?
                        ((SHOW_TICKS > HOLD_TICKS) ? SHOW_TICKS : HOLD_TICKS) :
                        ((GAP_TICKS > HOLD_TICKS) ? GAP_TICKS : HOLD_TICKS),
  localparam int CW   = $clog2(MAXT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          start,
  input  logic [3:0]    btn,
  output logic [3:0]    led,
  output logic          waiting,
  output logic          won,
  output logic          lost,
  output logic [SW-1:0] score
);

  typedef enum logic [2:0] {
    S_IDLE, S_SHOW, S_WAIT, S_HOLD, S_CHECK, S_LOST, S_WON
  } st_t;

  st_t           st;
  logic [SW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          lit;
  logic [3:0]    guess;
  logic [CW-1:0] lim;
  logic          last;
  logic [3:0]    expect_led;

  assign expect_led = 4'b0001 << idx[1:0];

  always_comb begin
    if (st == S_HOLD)  lim = CW'(HOLD_TICKS - 1);
    else if (lit)      lim = CW'(SHOW_TICKS - 1);
    else               lim = CW'(GAP_TICKS - 1);
  end

  assign last = tick && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      score <= '0;
      idx   <= '0;
      cnt   <= '0;
      lit   <= 1'b0;
      guess <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st  <= S_SHOW;
          idx <= '0;
          cnt <= '0;
          lit <= 1'b1;
        end
        S_SHOW: if (tick) begin
          if (last) begin
            cnt <= '0;
            if (lit) lit <= 1'b0;
            else if (idx == score) begin
              idx <= '0;
              st  <= S_WAIT;
            end else begin
              idx <= idx + 1'b1;
              lit <= 1'b1;
            end
          end else cnt <= cnt + 1'b1;
        end
        S_WAIT: if (|btn) begin
          guess <= btn;
          cnt   <= '0;
          st    <= S_HOLD;
        end
        S_HOLD: if (tick) begin
          if (last) begin
            cnt <= '0;
            st  <= S_CHECK;
          end else cnt <= cnt + 1'b1;
        end
        S_CHECK: begin
          if (guess != expect_led) st <= S_LOST;
          else if (idx != score) begin
            idx <= idx + 1'b1;
            st  <= S_WAIT;
          end else begin
            idx   <= '0;
            score <= score + 1'b1;
            if (score == SW'(WIN_SCORE - 1)) st <= S_WON;
            else begin
              st  <= S_SHOW;
              lit <= 1'b1;
              cnt <= '0;
            end
          end
        end
        default: st <= st;
      endcase
    end
  end

  assign led     = (st == S_SHOW && lit) ? expect_led :
                   (st == S_HOLD)        ? guess      : 4'b0000;
  assign waiting = (st == S_WAIT);
  assign won     = (st == S_WON);
  assign lost    = (st == S_LOST);

endmodule

// File: rtl/memseq_game_chk.sv
module memseq_game_chk #(
  parameter int WIN_SCORE = 15,
  localparam int SW = $clog2(WIN_SCORE + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic [3:0]    btn,
  input logic [3:0]    led,
  input logic          waiting,
  input logic          won,
  input logic          lost,
  input logic [SW-1:0] score
);

  AST_RESET_STATE: assert property (@(posedge clk)
    !rst_n |=> (score == '0 && !won && !lost && !waiting && led == 4'b0000)); // R1

  AST_PRESS_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    (waiting && btn != 4'b0000) |=> (!waiting && led == $past(btn))); // R6

  AST_SCORE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && score != $past(score)) |-> (score == $past(score) + 1'b1)); // R8

  AST_WIN_SCORE: assert property (@(posedge clk) disable iff (!rst_n)
    won |-> (score == SW'(WIN_SCORE))); // R10

  AST_END_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (won || lost) |=> ((won || lost) && $stable(won) && $stable(score))); // R11

  AST_END_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (won || lost) |-> (led == 4'b0000 && !waiting)); // R11

  AST_NO_TICK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !waiting && !won && !lost && led != 4'b0000) |=> $stable(led)); // R12

endmodule

bind memseq_game memseq_game_chk #(.WIN_SCORE(WIN_SCORE)) u_chk (.*);

// File: tb/test_memseq_game.sv
module test_memseq_game;
  localparam int SH = 3;
  localparam int GP = 2;
  localparam int HD = 2;
  localparam int WN = 15;
  localparam int SW = $clog2(WN + 1);

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, start = 1'b0;
  logic [3:0] btn = 4'b0000;
  logic [3:0] led;
  logic waiting, won, lost;
  logic [SW-1:0] score;

  int checks = 0, errors = 0;
  int tick_mode = 0;
  bit done = 1'b0;

  memseq_game #(.SHOW_TICKS(SH), .GAP_TICKS(GP), .HOLD_TICKS(HD), .WIN_SCORE(WN)) i_memseq_game (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start), .btn(btn),
    .led(led), .waiting(waiting), .won(won), .lost(lost), .score(score));

  always #2 clk = ~clk;

  function automatic logic [3:0] pat_f(int i);
    return 4'b0001 << (i % 4);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    tick = (tick_mode == 0) ? 1'b1 : (tick_mode == 2) ? 1'b0 : ($urandom_range(0, 2) != 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; start = 1'b0; btn = 4'b0000;
    repeat (3) cyc();
    rst_n = 1'b1;
    chk(led == 0 && score == 0 && !waiting && !won && !lost, "R1", int'(led) + int'(score), 0);
  endtask

  task automatic begin_game();
    cyc(); start = 1'b1; cyc(); start = 1'b0;
  endtask

  task automatic watch_show(int n);
    int seen = 0, run = 0, zrun = 0, guard = 0;
    logic [3:0] prev = 4'b0000;
    while (guard < 5000) begin
      if (waiting) break;
      if (led != 0) begin
        if (prev == 0) begin
          if (seen > 0 && tick_mode == 0) chk(zrun == GP, "R4 gap", zrun, GP);
          chk(seen < n && led == pat_f(seen), "R3", int'(led), int'(pat_f(seen)));
          seen++; run = 0;
        end
        chk($countones(led) == 1, "R4 onehot", $countones(led), 1);
        run++; zrun = 0;
      end else begin
        if (prev != 0 && tick_mode == 0) chk(run == SH, "R4 lit", run, SH);
        zrun++;
      end
      prev = led;
      cyc(); guard++;
    end
    chk(seen == n, "R4 count", seen, n);
    if (tick_mode == 0) chk(zrun == GP, "R5 gap", zrun, GP);
    chk(waiting, "R5", int'(waiting), 1);
  endtask

  task automatic press(logic [3:0] v);
    int h = 1, guard = 0;
    btn = v; cyc(); btn = 4'b0000;
    chk(led == v && !waiting, "R6", int'(led), int'(v));
    cyc();
    while (led != 0 && guard < 5000) begin h++; cyc(); guard++; end
    if (tick_mode == 0) chk(h == HD, "R6 hold", h, HD);
    cyc();
  endtask

  task automatic play(int fail_round, int fail_step, logic [3:0] wrong);
    logic [3:0] w;
    begin_game();
    for (int r = 0; r < WN; r++) begin
      watch_show(r + 1);
      for (int i = 0; i <= r; i++) begin
        if (r == fail_round && i == fail_step) begin
          w = wrong;
          if (w == 0) begin
            do w = 4'($urandom_range(1, 15)); while (w == pat_f(i));
          end
          press(w);
          chk(lost && !won, "R9", int'(lost), 1);
          chk(score == SW'(r), "R9 score", int'(score), r);
          return;
        end
        press(pat_f(i));
        if (i < r) chk(waiting && score == SW'(r), "R7", int'(score), r);
        else if (r + 1 == WN) chk(won && score == SW'(WN), "R10", int'(score), WN);
        else chk(!waiting && score == SW'(r + 1), "R8", int'(score), r + 1);
      end
    end
  endtask

  task automatic sticky(bit exp_won);
    logic [SW-1:0] s0 = score;
    start = 1'b1; btn = 4'b0001;
    repeat (4) cyc();
    start = 1'b0; btn = 4'b0000;
    cyc();
    chk(won == exp_won && lost == !exp_won && led == 0 && !waiting && score == s0,
        "R11", int'(won), int'(exp_won));
  endtask

  initial begin
    void'($urandom(32'd1234));
    do_reset();

    btn = 4'b0100; repeat (3) cyc(); btn = 4'b0000;
    chk(led == 0 && !waiting && score == 0, "R2 idle buttons", int'(led), 0);
    begin_game();
    chk(led == pat_f(0), "R2 start", int'(led), int'(pat_f(0)));

    tick_mode = 2;
    repeat (20) cyc();
    chk(led == pat_f(0) && !waiting, "R12", int'(led), int'(pat_f(0)));
    tick_mode = 0;

    do_reset();
    play(WN, 0, 4'b0000);
    sticky(1'b1);
    do_reset();

    play(0, 0, 4'b0011);
    sticky(1'b0);
    do_reset();

    play(3, 2, 4'b0000);

    for (int g = 0; g < 6; g++) begin
      int fr, fs;
      tick_mode = 1;
      do_reset();
      fr = $urandom_range(0, WN - 1);
      fs = $urandom_range(0, fr);
      play(fr, fs, 4'b0000);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule